// File: doc/BRIEF.md
# I2C Status Flag Controller

This block keeps the status flags of an I2C peripheral. The serial bus engine reports what happens on the bus through single-cycle event strobes: a Start condition was put on the bus, a Stop was seen, an acknowledge was missing, an acknowledge arrived, arbitration was lost, a bus error occurred, or a general-call address matched. The block latches each event into a flag. The flags are shown in two status registers that the CPU reads through a simple synchronous register port. Each flag is cleared by its own access pattern. The error and stop flags clear when status register 2 is read. The start flag needs two steps: a read of status register 1, then a write to the data register.

From the flags the block produces one interrupt request and a request to hold SCL low, which goes to the bit engine. Only the start flag stretches the clock. When the peripheral enable is dropped, every flag and the pending clear sequence are wiped. While the enable is low, bus events are ignored.

Register addresses (2-bit `addr`): 0 = control (write only; bit 0 is the START request), 1 = status register 1, 2 = status register 2, 3 = data register.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: After reset, `sr1_q`, `sr2_q` and `rd_data` are 00h, and `irq` and `scl_hold` are 0.
- R2: The master flag (`sr1_q` bit 1) sets on a control write (addr 0) with data bit 0 = 1. It clears on `evt_stop_det` or `evt_arb_lost`.
- R3: The start flag (`sr1_q` bit 0) sets on `evt_start_gen`. It clears only on a data-register write (addr 3) that follows a status register 1 read made while the flag was 1, with no other register access in between. A data write without that preceding read leaves it at 1.
- R4: The acknowledge-failure flag (`sr2_q` bit 4) sets on `evt_ack_miss`. It clears on a status register 2 read (addr 2).
- R5: The stop-detect flag (`sr2_q` bit 3) sets on `evt_stop_det` only when `ack_en` = 1 and an `evt_ack_rcvd` has occurred since the previous Stop. It clears on a status register 2 read.
- R6: The arbitration-lost (bit 2), bus-error (bit 1) and general-call (bit 0) flags of `sr2_q` set on `evt_arb_lost`, `evt_bus_err` and `evt_gen_call`. They clear on a status register 2 read.
- R7: When a set event and a clearing access fall in the same cycle, the set wins and the flag stays 1.
- R8: In `sr2_q`, bits 7:5 are always 0, and AF = 4, STOPF = 3, ARLO = 2, BERR = 1, GCAL = 0. In `sr1_q`, MSL = bit 1, SB = bit 0, and the rest is 0.
- R9: `scl_hold` follows the start flag only. The acknowledge-failure and stop-detect flags never raise it.
- R10: `irq` is 1 exactly when `irq_en` = 1 and at least one of SB, AF or STOPF is set.
- R11: While `per_en` = 0, all flags and the start-clear sequence clear on the next edge, and event strobes have no effect.
- R12: `rd_data` is registered. The cycle after a read strobe it holds the addressed register as it was before that read's clear. Reads of addresses 0 and 3 return 00h. Without a read strobe, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| per_en | input | 1 | Peripheral enable; 0 wipes all flags |
| irq_en | input | 1 | Interrupt enable |
| ack_en | input | 1 | Acknowledge enable, qualifies stop detection |
| evt_start_gen | input | 1 | Strobe: Start condition generated |
| evt_stop_det | input | 1 | Strobe: Stop condition detected |
| evt_ack_miss | input | 1 | Strobe: no acknowledge returned |
| evt_ack_rcvd | input | 1 | Strobe: acknowledge received |
| evt_arb_lost | input | 1 | Strobe: arbitration lost |
| evt_bus_err | input | 1 | Strobe: misplaced Start/Stop |
| evt_gen_call | input | 1 | Strobe: general-call address matched |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sr1_q | output | 8 | Status register 1 contents |
| sr2_q | output | 8 | Status register 2 contents |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
A flag's set event and its clearing access can land in the same cycle. One case is an acknowledge-missing strobe together with a status register 2 read. The other is a Start strobe together with the data-register write that should finish the two-step clear of the start flag. The bench drives both pairs on one edge. It expects the read to return the flag's old value of 1 and the flag to stay 1 afterwards. A second, lone read or write must then clear the flag.

// File: rtl/i2c_flag_pkg.sv
// Package: shared register addresses, bit positions and the decoded access type
// for the I2C status flag controller. It assumes a 2-bit register address space.
package i2c_flag_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_SR1  = 2'd1,
        REG_SR2  = 2'd2,
        REG_DATA = 2'd3
    } reg_addr_e;

    // Status register 1 bit positions
    localparam int SR1_SB  = 0;
    localparam int SR1_MSL = 1;

    // Status register 2 bit positions (decoded by software, so they are fixed)
    localparam int SR2_GCAL  = 0;
    localparam int SR2_BERR  = 1;
    localparam int SR2_ARLO  = 2;
    localparam int SR2_STOPF = 3;
    localparam int SR2_AF    = 4;
    localparam int SR2_NFLAG = 5;

    // Control register START request bit
    localparam int CTRL_START = 0;

    typedef struct packed {
        logic rd_sr1;
        logic rd_sr2;
        logic wr_ctrl;
        logic wr_data;
        logic any_acc;
    } acc_t;

endpackage

// File: rtl/i2c_acc_decode.sv
// Access decoder: turns the read/write strobes and the address into one-hot
// access qualifiers. Assumes at most one strobe per cycle; both count as an access.
module i2c_acc_decode
    import i2c_flag_pkg::*;
(
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);

    // Decode the strobes against the address map
    always_comb begin
        acc.rd_sr1  = rd && (addr == REG_SR1);
        acc.rd_sr2  = rd && (addr == REG_SR2);
        acc.wr_ctrl = wr && (addr == REG_CTRL);
        acc.wr_data = wr && (addr == REG_DATA);
        acc.any_acc = rd || wr;
    end

endmodule

// File: rtl/i2c_sticky_flag.sv
// Sticky flag: set by an event, cleared by an access. When both occur in the
// same cycle, the set wins. A low enable clears the flag and blocks the set.
module i2c_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Flag register with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (!en)    q <= 1'b0;
        else if (set)    q <= 1'b1;
        else if (clr)    q <= 1'b0;
    end

endmodule

// File: rtl/i2c_sb_track.sv
// Start flag tracker: holds the start flag and an armed bit for its two-step clear.
// A status register 1 read while the flag is 1 arms the clear. Any other access
// disarms it. A data-register write clears the flag only while armed.
// Assumes the decoded strobes come from i2c_acc_decode.
module i2c_sb_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set,
    input  logic rd_sr1,
    input  logic wr_data,
    input  logic any_acc,
    output logic sb
);

    logic armed;

    // Start flag: set wins over an armed data write
    always_ff @(posedge clk) begin
        if (!rst_n)                 sb <= 1'b0;
        else if (!en)               sb <= 1'b0;
        else if (set)               sb <= 1'b1;
        else if (wr_data && armed)  sb <= 1'b0;
    end

    // Armed bit: a read of register 1 while the flag is set arms it; any other access drops it
    always_ff @(posedge clk) begin
        if (!rst_n)                 armed <= 1'b0;
        else if (!en)               armed <= 1'b0;
        else if (rd_sr1 && sb)      armed <= 1'b1;
        else if (any_acc)           armed <= 1'b0;
    end

endmodule

// File: rtl/i2c_flag_ctrl.sv
// I2C status flag controller (top). It latches bus-engine event strobes into the
// status flags, clears them by register-access sequences, and drives the interrupt
// and SCL-hold requests. Assumes single-cycle synchronous register strobes and
// DATA_W >= SR2_NFLAG.
module i2c_flag_ctrl
    import i2c_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_en,
    input  logic              irq_en,
    input  logic              ack_en,
    input  logic              evt_start_gen,
    input  logic              evt_stop_det,
    input  logic              evt_ack_miss,
    input  logic              evt_ack_rcvd,
    input  logic              evt_arb_lost,
    input  logic              evt_bus_err,
    input  logic              evt_gen_call,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sr1_q,
    output logic [DATA_W-1:0] sr2_q,
    output logic              irq,
    output logic              scl_hold
);

    localparam int SR1_USED = SR1_MSL + 1;

    acc_t                 acc;
    logic                 sb;
    logic                 msl;
    logic                 ack_seen;
    logic [SR2_NFLAG-1:0] sr2_set;
    logic [SR2_NFLAG-1:0] sr2_flag;
    logic                 wdata_unused;

    // Only the START bit of write data matters here; the data byte goes to the shifter
    assign wdata_unused = ^wdata;

    i2c_acc_decode u_dec (
        .rd   (rd),
        .wr   (wr),
        .addr (addr),
        .acc  (acc)
    );

    i2c_sb_track u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (per_en),
        .set     (evt_start_gen),
        .rd_sr1  (acc.rd_sr1),
        .wr_data (acc.wr_data),
        .any_acc (acc.any_acc),
        .sb      (sb)
    );

    // Master flag: set by the START request, cleared by Stop or arbitration loss
    i2c_sticky_flag u_msl (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (per_en),
        .set   (acc.wr_ctrl && wdata[CTRL_START]),
        .clr   (evt_stop_det || evt_arb_lost),
        .q     (msl)
    );

    // Acknowledge-seen tracker: qualifies the stop-detect flag
    i2c_sticky_flag u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (per_en),
        .set   (evt_ack_rcvd),
        .clr   (evt_stop_det),
        .q     (ack_seen)
    );

    // Gather the set events of status register 2 by bit position
    always_comb begin
        sr2_set            = '0;
        sr2_set[SR2_AF]    = evt_ack_miss;
        sr2_set[SR2_STOPF] = evt_stop_det && ack_en && ack_seen;
        sr2_set[SR2_ARLO]  = evt_arb_lost;
        sr2_set[SR2_BERR]  = evt_bus_err;
        sr2_set[SR2_GCAL]  = evt_gen_call;
    end

    // One sticky flag for each bit of status register 2, all cleared by its read
    for (genvar i = 0; i < SR2_NFLAG; i++) begin : g_sr2
        i2c_sticky_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (per_en),
            .set   (sr2_set[i]),
            .clr   (acc.rd_sr2),
            .q     (sr2_flag[i])
        );
    end

    // Assemble the two status registers; unused bits read 0
    always_comb begin
        sr1_q          = '0;
        sr1_q[SR1_SB]  = sb;
        sr1_q[SR1_MSL] = msl;
        sr2_q          = '0;
        sr2_q[SR2_NFLAG-1:0] = sr2_flag;
    end

    // Requests: only the start flag stretches SCL
    assign scl_hold = sb;
    assign irq      = irq_en && (sb || sr2_flag[SR2_AF] || sr2_flag[SR2_STOPF]);

    // Registered read data, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd) begin
            case (addr)
                REG_SR1: rd_data <= sr1_q;
                REG_SR2: rd_data <= sr2_q;
                default: rd_data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/i2c_flag_ctrl_chk.sv
// Assertion checker for i2c_flag_ctrl, bound to every instance of the top.
// It observes only the ports and assumes the address map of i2c_flag_pkg.
module i2c_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       per_en,
    input logic       irq_en,
    input logic       evt_ack_miss,
    input logic       evt_arb_lost,
    input logic       rd,
    input logic       wr,
    input logic [1:0] addr,
    input logic       wstart,
    input logic [7:0] rd_data,
    input logic [7:0] sr1_q,
    input logic [7:0] sr2_q,
    input logic       irq,
    input logic       scl_hold
);

    assert_sr2_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sr2_q[7:5] == 3'b000);

    assert_hold_only_sb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold == sr1_q[0]);

    assert_irq_sources_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (irq_en && (sr1_q[0] || sr2_q[4] || sr2_q[3])));

    assert_disable_wipes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !per_en |=> (sr1_q == 8'h00 && sr2_q == 8'h00));

    // R7: a set beats a read of status register 2 in the same cycle
    assert_af_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && evt_ack_miss) |=> sr2_q[4]);

    assert_arlo_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && rd && addr == 2'd2 && !evt_arb_lost) |=> !sr2_q[2]);

    assert_start_sets_msl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (per_en && wr && addr == 2'd0 && wstart) |=> sr1_q[1]);

    assert_sb_clear_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr1_q[0]) |-> $past((wr && addr == 2'd3) || !per_en));

    assert_rdata_sr2_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == 2'd2) |=> rd_data == $past(sr2_q));

endmodule

bind i2c_flag_ctrl i2c_flag_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .per_en       (per_en),
    .irq_en       (irq_en),
    .evt_ack_miss (evt_ack_miss),
    .evt_arb_lost (evt_arb_lost),
    .rd           (rd),
    .wr           (wr),
    .addr         (addr),
    .wstart       (wdata[0]),
    .rd_data      (rd_data[7:0]),
    .sr1_q        (sr1_q[7:0]),
    .sr2_q        (sr2_q[7:0]),
    .irq          (irq),
    .scl_hold     (scl_hold)
);

// File: tb/sim_i2c_flag_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench for i2c_flag_ctrl. Read tasks queue the expected read data and
// a monitor compares rd_data when it appears. Flag ports are checked directly.
module sim_i2c_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       per_en = 1'b0, irq_en = 1'b0, ack_en = 1'b0;
    logic       evt_start_gen = 1'b0, evt_stop_det = 1'b0, evt_ack_miss = 1'b0;
    logic       evt_ack_rcvd = 1'b0, evt_arb_lost = 1'b0, evt_bus_err = 1'b0;
    logic       evt_gen_call = 1'b0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rd_data, sr1_q, sr2_q;
    logic       irq, scl_hold;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         chk_pend = 1'b0;

    always #2 clk = ~clk;

    i2c_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .per_en(per_en), .irq_en(irq_en), .ack_en(ack_en),
        .evt_start_gen(evt_start_gen), .evt_stop_det(evt_stop_det),
        .evt_ack_miss(evt_ack_miss), .evt_ack_rcvd(evt_ack_rcvd),
        .evt_arb_lost(evt_arb_lost), .evt_bus_err(evt_bus_err),
        .evt_gen_call(evt_gen_call), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .sr1_q(sr1_q), .sr2_q(sr2_q), .irq(irq), .scl_hold(scl_hold)
    );

    // Monitor: compares registered read data one cycle after each read strobe
    always @(negedge clk) begin
        if (chk_pend) begin
            vecs++;
            if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL read monitor: unexpected read data %02h, expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errs++;
                    $display("FAIL %s: rd_data %02h, expected %02h", t, rd_data, e);
                end
            end
        end
        chk_pend = rd;
    end

    // Advance one edge, then drop all single-cycle strobes
    task automatic cyc();
        @(posedge clk);
        #1;
        evt_start_gen = 0; evt_stop_det = 0; evt_ack_miss = 0; evt_ack_rcvd = 0;
        evt_arb_lost = 0; evt_bus_err = 0; evt_gen_call = 0; rd = 0; wr = 0;
    endtask

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string t);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %02h, expected %02h", t, got, exp);
        end
    endtask

    // Driver: queue the expected read data and issue the read strobe
    task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd = 1; addr = a;
        cyc();
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        wr = 1; addr = a; wdata = d;
        cyc();
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1; per_en = 1; ack_en = 1;
        cyc();
        // R1: reset state
        chk(sr1_q, 8'h00, "R1 sr1");
        chk(sr2_q, 8'h00, "R1 sr2");
        chk({6'd0, irq, scl_hold}, 8'h00, "R1 irq/hold");
        chk(rd_data, 8'h00, "R1 rd_data");

        // R2: master flag set by START, cleared by stop, then by arbitration loss
        wr_reg(2'd0, 8'h01);
        chk(sr1_q, 8'h02, "R2 msl set");
        evt_stop_det = 1; cyc();
        chk(sr1_q, 8'h00, "R2 msl cleared by stop");
        wr_reg(2'd0, 8'h01);
        evt_arb_lost = 1; cyc();
        chk(sr1_q, 8'h00, "R2 msl cleared by arb loss");
        // R6: arbitration-lost flag read then cleared
        chk(sr2_q, 8'h04, "R6 arlo set");
        rd_exp(2'd2, 8'h04, "R6 arlo read");
        chk(sr2_q, 8'h00, "R6 arlo cleared");

        // R3/R9/R10: start flag and its two-step clear
        evt_start_gen = 1; cyc();
        chk(sr1_q, 8'h01, "R3 sb set");
        chk({7'd0, scl_hold}, 8'h01, "R9 hold with sb");
        chk({7'd0, irq}, 8'h00, "R10 irq masked");
        irq_en = 1; cyc();
        chk({7'd0, irq}, 8'h01, "R10 irq from sb");
        wr_reg(2'd3, 8'hA5);
        chk(sr1_q, 8'h01, "R3 data write without read");
        rd_exp(2'd1, 8'h01, "R3 sr1 read");
        rd_exp(2'd2, 8'h00, "R3 other access");
        wr_reg(2'd3, 8'hA5);
        chk(sr1_q, 8'h01, "R3 disarmed by other access");
        rd_exp(2'd1, 8'h01, "R3 sr1 read again");
        wr_reg(2'd3, 8'h5A);
        chk(sr1_q, 8'h00, "R3 sb cleared");
        chk({6'd0, irq, scl_hold}, 8'h00, "R9 irq/hold drop");

        // R4/R9: acknowledge failure
        evt_ack_miss = 1; cyc();
        chk(sr2_q, 8'h10, "R4 af set");
        chk({7'd0, scl_hold}, 8'h00, "R9 af no hold");
        chk({7'd0, irq}, 8'h01, "R10 irq from af");
        rd_exp(2'd2, 8'h10, "R4 af read");
        chk(sr2_q, 8'h00, "R4 af cleared");
        chk({7'd0, irq}, 8'h00, "R10 irq gone");

        // R5: stop detection qualified by an acknowledge and ack_en
        evt_stop_det = 1; cyc();
        chk(sr2_q, 8'h00, "R5 stop without ack");
        evt_ack_rcvd = 1; cyc();
        evt_stop_det = 1; cyc();
        chk(sr2_q, 8'h08, "R5 stopf set");
        chk({6'd0, irq, scl_hold}, 8'h02, "R9 stopf no hold");
        rd_exp(2'd2, 8'h08, "R5 stopf read");
        chk(sr2_q, 8'h00, "R5 stopf cleared");
        ack_en = 0;
        evt_ack_rcvd = 1; cyc();
        evt_stop_det = 1; cyc();
        chk(sr2_q, 8'h00, "R5 ack_en low");
        ack_en = 1;

        // R6: bus error and general call
        evt_bus_err = 1; evt_gen_call = 1; cyc();
        chk(sr2_q, 8'h03, "R6 berr/gcal set");
        rd_exp(2'd2, 8'h03, "R6 berr/gcal read");
        chk(sr2_q, 8'h00, "R6 berr/gcal cleared");

        // R7: set beats clear in the same cycle
        evt_ack_miss = 1; cyc();
        evt_ack_miss = 1; rd_exp(2'd2, 8'h10, "R7 af read with set");
        chk(sr2_q, 8'h10, "R7 af stays");
        rd_exp(2'd2, 8'h10, "R7 af plain read");
        chk(sr2_q, 8'h00, "R7 af cleared");
        evt_start_gen = 1; cyc();
        rd_exp(2'd1, 8'h01, "R7 arm sb");
        evt_start_gen = 1; wr_reg(2'd3, 8'h11);
        chk(sr1_q, 8'h01, "R7 sb stays");
        rd_exp(2'd1, 8'h01, "R7 rearm sb");
        wr_reg(2'd3, 8'h11);
        chk(sr1_q, 8'h00, "R7 sb cleared");

        // R11: disable wipes and blocks
        evt_ack_miss = 1; evt_start_gen = 1; wr = 1; addr = 2'd0; wdata = 8'h01; cyc();
        chk(sr1_q, 8'h03, "R11 pre sr1");
        chk(sr2_q, 8'h10, "R11 pre sr2");
        per_en = 0; cyc();
        chk(sr1_q, 8'h00, "R11 sr1 wiped");
        chk(sr2_q, 8'h00, "R11 sr2 wiped");
        evt_ack_miss = 1; evt_start_gen = 1; evt_gen_call = 1; cyc();
        chk(sr1_q, 8'h00, "R11 sr1 ignored");
        chk(sr2_q, 8'h00, "R11 sr2 ignored");
        rd_exp(2'd1, 8'h00, "R11 read while off");
        per_en = 1;
        evt_start_gen = 1; cyc();
        rd_exp(2'd1, 8'h01, "R11 arm before disable");
        per_en = 0; cyc();
        per_en = 1;
        evt_start_gen = 1; cyc();
        wr_reg(2'd3, 8'h22);
        chk(sr1_q, 8'h01, "R11 armed state wiped");
        rd_exp(2'd1, 8'h01, "R11 rearm");
        wr_reg(2'd3, 8'h22);
        chk(sr1_q, 8'h00, "R11 sb cleared after rearm");

        // R12/R8: read map and hold behaviour
        wr_reg(2'd0, 8'h01);
        evt_start_gen = 1; cyc();
        rd_exp(2'd1, 8'h03, "R8 sr1 layout");
        rd_exp(2'd0, 8'h00, "R12 ctrl reads zero");
        rd_exp(2'd3, 8'h00, "R12 data reads zero");
        evt_arb_lost = 1; cyc();
        rd_exp(2'd2, 8'h04, "R12 sr2 read");
        cyc(); cyc();
        chk(rd_data, 8'h04, "R12 rd_data holds");

        repeat (3) cyc();
        vecs++;
        if (exp_q.size() != 0) begin
            errs++;
            $display("FAIL scoreboard R12: %0d reads pending, expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule